// File: doc/BRIEF.md
# Shift and Rotate Unit

This unit moves the bits of an 8-bit or 16-bit operand by a programmable number of places. It offers seven moves: logical left and right shifts, an arithmetic right shift that keeps the sign, plain left and right rotates, and left and right rotates that treat the carry flag as one extra bit of the ring. A request carries the operand, a width select, an operation code, a count, the incoming carry and the current overflow, sign, zero and parity flags. The unit returns the moved operand together with the new carry, overflow, sign, zero and parity flags.

The work is iterative. The unit takes one clock per bit position, so a count of N costs N cycles between acceptance and result. Requests enter on a valid/ready handshake. `in_ready` is high only while the unit is idle. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. The result is then held, with `out_valid` high, until the consumer raises `out_ready`. While a result is held or a move is running, `in_ready` stays low, which back-pressures the producer. Requests offered during that time are not taken.

Top module: `shift_rotate_unit`

## Requirements
- R1: `in_ready` and `out_valid` are never high together. A request is taken only on an edge with `in_valid` and `in_ready` high. While `out_valid` is high and `out_ready` is low, the result and all output flags stay unchanged. Requests offered while the unit is busy or holding a result have no effect on that result.
- R2: Operation code 0 is a logical left shift. Each step moves in a zero at bit 0, and carry receives the bit shifted out of the most significant position.
- R3: Operation code 1 is a logical right shift. Each step moves in a zero at the most significant position, and carry receives the bit shifted out of bit 0.
- R4: Operation code 2 is an arithmetic right shift. The most significant bit keeps its old value on every step, and carry receives the bit leaving bit 0 (8-bit 0x1D by one gives 0x0E with carry 1).
- R5: Operation code 3 rotates left: the most significant bit goes to bit 0 and to carry. Operation code 4 rotates right: bit 0 goes to the most significant position and to carry.
- R6: Operation codes 5 (left) and 6 (right) rotate through carry. The carry enters the vacated end, and the bit leaving the other end becomes the new carry. The ring is therefore width+1 bits long, and a count of width+1 restores the operand and the carry.
- R7: A count of N performs N single-bit steps, and `out_valid` rises N clock edges after the accepting edge. A count of 0 returns the operand with all five flags equal to their inputs.
- R8: For N>0, the overflow output is 1 exactly when the most significant bit differs before and after the last step. This gives the original MSB for a one-place logical right shift and 0 for an arithmetic right shift.
- R9: After a shift (codes 0 to 2) with N>0, sign is the result MSB, zero is 1 when the result is 0, and parity is 1 when the low 8 bits hold an even number of ones. After a rotate, the sign, zero and parity outputs equal their inputs.
- R10: When `in_narrow` is 1, only the low 8 bits take part, bit 7 is the most significant bit, and the upper byte of the result is 0 whatever the upper operand bits were.
- R11: After reset, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Unit idle and able to take a request |
| in_op | input | 3 | Operation code (0 to 6; 7 reserved) |
| in_narrow | input | 1 | 1 selects 8-bit operand, 0 selects 16-bit |
| in_count | input | 5 | Number of positions to move |
| in_opnd | input | 16 | Operand |
| in_cf | input | 1 | Incoming carry flag |
| in_of | input | 1 | Incoming overflow flag |
| in_sf | input | 1 | Incoming sign flag |
| in_zf | input | 1 | Incoming zero flag |
| in_pf | input | 1 | Incoming parity flag |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | 16 | Moved operand |
| out_cf | output | 1 | Carry flag |
| out_of | output | 1 | Overflow flag |
| out_sf | output | 1 | Sign flag |
| out_zf | output | 1 | Zero flag |
| out_pf | output | 1 | Parity flag |

## Verification
The bench runs every operation at both widths, using operands chosen to separate one move from another. A single set MSB tells a logical shift from a rotate. A zero operand with carry set tells a plain rotate from a rotate through carry. A negative word tells an arithmetic right shift from a logical one. Multi-step counts show that carry and overflow follow the last step and not the first. A count of width+1 through carry, a count of zero, and an 8-bit request with junk in the upper byte cover the ring length, the pass-through case and the width masking. A held result under back-pressure, with a competing request offered, shows the handshake rules.

// File: rtl/sru_pkg.sv
package sru_pkg;

  typedef enum logic [2:0] {
    OP_SHL = 3'd0,
    OP_SHR = 3'd1,
    OP_SAR = 3'd2,
    OP_ROL = 3'd3,
    OP_ROR = 3'd4,
    OP_RCL = 3'd5,
    OP_RCR = 3'd6
  } sru_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } sru_state_e;

endpackage

// File: rtl/sru_step.sv
module sru_step
  import sru_pkg::*;
#(
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  logic [DW-1:0] val,
  input  logic          cf_in,
  input  logic [2:0]    op,
  input  logic          narrow,
  output logic [DW-1:0] val_out,
  output logic          cf_out
);
  localparam logic [DW-1:0] ONE      = DW'(1);
  localparam logic [DW-1:0] LOW_MASK = {{(DW-BW){1'b0}}, {BW{1'b1}}};
  localparam logic [DW-1:0] TOP_W    = ONE << (DW-1);
  localparam logic [DW-1:0] TOP_N    = ONE << (BW-1);

  logic [DW-1:0] mask, topm, up, dn;
  logic          top, lsb;

  always_comb begin
    mask = narrow ? LOW_MASK : '1;
    topm = narrow ? TOP_N : TOP_W;
    top  = |(val & topm);
    lsb  = val[0];
    up   = (val << 1) & mask;
    dn   = (val & mask) >> 1;
    case (op)
      OP_SHL: begin val_out = up;                             cf_out = top; end
      OP_SHR: begin val_out = dn;                             cf_out = lsb; end
      OP_SAR: begin val_out = dn | (top ? topm : '0);         cf_out = lsb; end
      OP_ROL: begin val_out = up | {{(DW-1){1'b0}}, top};     cf_out = top; end
      OP_ROR: begin val_out = dn | (lsb ? topm : '0);         cf_out = lsb; end
      OP_RCL: begin val_out = up | {{(DW-1){1'b0}}, cf_in};   cf_out = top; end
      OP_RCR: begin val_out = dn | (cf_in ? topm : '0);       cf_out = lsb; end
      default: begin val_out = val & mask;                    cf_out = cf_in; end
    endcase
  end
endmodule

// File: rtl/sru_flags.sv
module sru_flags #(
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  logic [DW-1:0] val,
  input  logic          narrow,
  output logic          sgn,
  output logic          zero,
  output logic          par
);
  always_comb begin
    sgn  = narrow ? val[BW-1] : val[DW-1];
    zero = ~|val;
    par  = ~^val[BW-1:0];
  end
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import sru_pkg::*;
#(
  parameter int DW = 16,
  parameter int BW = 8,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    in_op,
  input  logic          in_narrow,
  input  logic [CW-1:0] in_count,
  input  logic [DW-1:0] in_opnd,
  input  logic          in_cf,
  input  logic          in_of,
  input  logic          in_sf,
  input  logic          in_zf,
  input  logic          in_pf,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_res,
  output logic          out_cf,
  output logic          out_of,
  output logic          out_sf,
  output logic          out_zf,
  output logic          out_pf
);
  localparam logic [DW-1:0] LOW_MASK  = {{(DW-BW){1'b0}}, {BW{1'b1}}};
  localparam logic [DW-1:0] FULL_MASK = '1;

  sru_state_e    st;
  logic [DW-1:0] work, nxt_work;
  logic [CW-1:0] rem;
  logic [2:0]    op_q;
  logic          narrow_q, cf_q, of_q, sf_q, zf_q, pf_q;
  logic          nxt_cf, f_sf, f_zf, f_pf, is_shift, take;

  function automatic logic msb_of(input logic [DW-1:0] v, input logic n);
    return n ? v[BW-1] : v[DW-1];
  endfunction

  sru_step #(.DW(DW), .BW(BW)) u_step (
    .val(work), .cf_in(cf_q), .op(op_q), .narrow(narrow_q),
    .val_out(nxt_work), .cf_out(nxt_cf)
  );

  sru_flags #(.DW(DW), .BW(BW)) u_flags (
    .val(nxt_work), .narrow(narrow_q),
    .sgn(f_sf), .zero(f_zf), .par(f_pf)
  );

  assign is_shift  = (op_q == OP_SHL) || (op_q == OP_SHR) || (op_q == OP_SAR);
  assign in_ready  = (st == ST_IDLE);
  assign out_valid = (st == ST_DONE);
  assign take      = in_valid && in_ready;
  assign out_res   = work;
  assign out_cf    = cf_q;
  assign out_of    = of_q;
  assign out_sf    = sf_q;
  assign out_zf    = zf_q;
  assign out_pf    = pf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      work     <= '0;
      rem      <= '0;
      op_q     <= '0;
      narrow_q <= 1'b0;
      cf_q     <= 1'b0;
      of_q     <= 1'b0;
      sf_q     <= 1'b0;
      zf_q     <= 1'b0;
      pf_q     <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (take) begin
          work     <= in_opnd & (in_narrow ? LOW_MASK : FULL_MASK);
          rem      <= in_count;
          op_q     <= in_op;
          narrow_q <= in_narrow;
          cf_q     <= in_cf;
          of_q     <= in_of;
          sf_q     <= in_sf;
          zf_q     <= in_zf;
          pf_q     <= in_pf;
          st       <= (in_count == '0) ? ST_DONE : ST_RUN;
        end
        ST_RUN: begin
          work <= nxt_work;
          cf_q <= nxt_cf;
          of_q <= msb_of(nxt_work, narrow_q) ^ msb_of(work, narrow_q);
          if (is_shift) begin
            sf_q <= f_sf;
            zf_q <= f_zf;
            pf_q <= f_pf;
          end
          rem <= rem - 1'b1;
          if (rem == CW'(1)) st <= ST_DONE;
        end
        ST_DONE: if (out_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R1
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R1
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res) && $stable(out_cf)
                                   && $stable(out_of) && $stable(out_sf)
                                   && $stable(out_zf) && $stable(out_pf)));

  // R4
  sar_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && op_q == OP_SAR) |=> $stable(msb_of(work, narrow_q)));

  // R7
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_count == '0) |=>
      (out_valid && out_res == $past(in_opnd & (in_narrow ? LOW_MASK : FULL_MASK))
       && out_cf == $past(in_cf) && out_of == $past(in_of)));

  // R10
  narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && narrow_q) |-> (out_res[DW-1:BW] == '0));

endmodule

// File: tb/shift_rotate_unit_bench.sv
module shift_rotate_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_narrow = 1'b0, in_cf = 1'b0;
  logic        in_of = 1'b0, in_sf = 1'b1, in_zf = 1'b1, in_pf = 1'b1;
  logic [2:0]  in_op = '0;
  logic [4:0]  in_count = '0;
  logic [15:0] in_opnd = '0;
  logic        out_ready = 1'b0;
  logic        in_ready, out_valid;
  logic [15:0] out_res;
  logic        out_cf, out_of, out_sf, out_zf, out_pf;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  shift_rotate_unit u_shift_rotate_unit (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_narrow(in_narrow), .in_count(in_count), .in_opnd(in_opnd),
    .in_cf(in_cf), .in_of(in_of), .in_sf(in_sf), .in_zf(in_zf), .in_pf(in_pf),
    .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res),
    .out_cf(out_cf), .out_of(out_of), .out_sf(out_sf), .out_zf(out_zf), .out_pf(out_pf)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic        nar;
    logic [4:0]  cnt;
    logic [15:0] opnd;
    logic        cin;
    logic [15:0] res;
    logic [4:0]  fl;   // {cf, of, sf, zf, pf}
  } vec_t;

  // incoming flags for every vector: of=0 sf=1 zf=1 pf=1
  localparam vec_t VECS [14] = '{
    '{3'd2, 1'b1, 5'd1, 16'h001D, 1'b0, 16'h000E, 5'b10000},
    '{3'd0, 1'b1, 5'd1, 16'h0081, 1'b0, 16'h0002, 5'b11000},
    '{3'd1, 1'b0, 5'd1, 16'h8001, 1'b0, 16'h4000, 5'b11001},
    '{3'd0, 1'b0, 5'd4, 16'h1234, 1'b0, 16'h2340, 5'b11000},
    '{3'd3, 1'b1, 5'd1, 16'h0080, 1'b0, 16'h0001, 5'b11111},
    '{3'd4, 1'b0, 5'd3, 16'h0001, 1'b0, 16'h2000, 5'b00111},
    '{3'd5, 1'b1, 5'd1, 16'h0000, 1'b1, 16'h0001, 5'b00111},
    '{3'd3, 1'b1, 5'd1, 16'h0000, 1'b1, 16'h0000, 5'b00111},
    '{3'd6, 1'b1, 5'd2, 16'h0001, 1'b1, 16'h00C0, 5'b00111},
    '{3'd1, 1'b1, 5'd8, 16'h00FF, 1'b0, 16'h0000, 5'b10011},
    '{3'd0, 1'b0, 5'd0, 16'hABCD, 1'b1, 16'hABCD, 5'b10111},
    '{3'd2, 1'b0, 5'd4, 16'h8000, 1'b0, 16'hF800, 5'b00101},
    '{3'd0, 1'b1, 5'd1, 16'hFF01, 1'b0, 16'h0002, 5'b00000},  // R10 upper junk
    '{3'd5, 1'b1, 5'd9, 16'h005A, 1'b0, 16'h005A, 5'b00111}   // R6 full ring
  };

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3, 3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Drives a request, waits for acceptance, returns cycles until out_valid.
  task automatic issue(input logic [2:0] op, input logic nar, input logic [4:0] cnt,
                       input logic [15:0] opnd, input logic cin, output int lat);
    @(negedge clk);
    in_op = op; in_narrow = nar; in_count = cnt; in_opnd = opnd; in_cf = cin;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!out_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic drain();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        summary();
      end
    end
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "in_ready after reset", 32'(in_ready), 32'd1);
    chk("R11", "out_valid after reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "in_ready idle", 32'(in_ready), 32'd1);

    for (int i = 0; i < 14; i++) begin
      issue(VECS[i].op, VECS[i].nar, VECS[i].cnt, VECS[i].opnd, VECS[i].cin, lat);
      chk(op_tag(VECS[i].op), $sformatf("vec %0d result", i), 32'(out_res), 32'(VECS[i].res));
      chk("R8/R9", $sformatf("vec %0d flags cf,of,sf,zf,pf", i),
          32'({out_cf, out_of, out_sf, out_zf, out_pf}), 32'(VECS[i].fl));
      chk("R7", $sformatf("vec %0d latency", i), 32'(lat), 32'(VECS[i].cnt));
      if (VECS[i].nar)
        chk("R10", $sformatf("vec %0d upper byte", i), 32'(out_res[15:8]), 32'd0);
      drain();
    end

    // R1 back-pressure and requests offered while busy
    @(negedge clk);
    in_op = 3'd0; in_narrow = 1'b0; in_count = 5'd2; in_opnd = 16'h0003; in_cf = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);                   // accepted at the edge before
    in_opnd = 16'h7777; in_op = 3'd3; // competing request kept valid
    chk("R1", "in_ready while running", 32'(in_ready), 32'd0);
    repeat (2) @(negedge clk);
    chk("R1", "out_valid after two steps", 32'(out_valid), 32'd1);
    repeat (5) @(negedge clk);
    chk("R1", "out_valid held", 32'(out_valid), 32'd1);
    chk("R1", "in_ready while holding", 32'(in_ready), 32'd0);
    chk("R1", "held result ignores busy request", 32'(out_res), 32'h000C);
    in_valid = 1'b0;
    drain();
    chk("R1", "out_valid after take", 32'(out_valid), 32'd0);
    chk("R11", "in_ready after take", 32'(in_ready), 32'd1);

    // R4 word sign kept over many steps
    issue(3'd2, 1'b0, 5'd15, 16'h8000, 1'b0, lat);
    chk("R4", "sar 15 of 0x8000", 32'(out_res), 32'hFFFF);
    chk("R8", "sar overflow", 32'(out_of), 32'd0);
    drain();

    // R6 word ring of 17 restores operand and carry
    issue(3'd6, 1'b0, 5'd17, 16'h1234, 1'b1, lat);
    chk("R6", "rcr 17 word result", 32'(out_res), 32'h1234);
    chk("R6", "rcr 17 word carry", 32'(out_cf), 32'd1);
    drain();

    summary();
  end
endmodule